// File: doc/BRIEF.md
# Byte-Wide Convolutional Interleaver

This block spreads a byte stream over a bank of branches so that neighbouring bytes travel through different delays. An input selector and an output selector always point at the same branch and move one step each time a byte is strobed in. After the last branch they return to the first. The branch with index k holds each of its bytes for k·STAGE of its own visits. Branch 0 is a straight wire, and branch BRANCHES-1 has the longest delay line. As a result, the byte that enters as the j-th strobe reappears at the output k·STAGE·BRANCHES strobes later, where k = j mod BRANCHES.

All delay lines share one inferred RAM of STAGE·BRANCHES·(BRANCHES-1)/2 bytes. Each branch owns a slice of the RAM, found from a fixed base offset plus a circular pointer that belongs to that branch. The interface is a plain byte strobe. There is no back-pressure: the consumer must take every output strobe, and the producer may leave gaps whenever it likes. The output strobe follows the input strobe one cycle later. A flag marks the point where every branch has been filled with real data.

Top module: `conv_interleaver`

## Requirements
- R1: A byte strobed in while the selector is on branch 0 appears on `out_data` unchanged, with `out_stb` high, in the next cycle.
- R2: The j-th strobed byte since reset (j counted from 0), taken on branch k = j mod BRANCHES with j ≥ k·STAGE·BRANCHES, produces on its output strobe the byte that was strobed in k·STAGE·BRANCHES strobes earlier.
- R3: The selector moves only on strobed cycles. It steps 0,1,…,BRANCHES-1 and then returns to 0, so idle cycles between strobes do not change which branch the next byte uses.
- R4: `out_stb` equals `in_stb` delayed by exactly one clock cycle.
- R5: For a byte taken on branch k with j < k·STAGE·BRANCHES, the output byte is 0x00, because the delay lines start out cleared.
- R6: `out_primed` is high on the output strobe of byte j exactly when j ≥ (BRANCHES-1)·STAGE·BRANCHES. Once high, it stays high until reset.
- R7: On cycles with `in_stb` low, `in_data` is ignored and `out_data` and `out_primed` hold their previous values.
- R8: A synchronous reset (`rst` high at a clock edge) returns the selector to branch 0, clears all circular pointers and all stored bytes, and forces `out_stb`, `out_primed` and `out_data` to zero. A stream started after reset behaves as if from power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_stb | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | W | Input byte |
| out_stb | output | 1 | Output byte strobe, one cycle after `in_stb` |
| out_data | output | W | Interleaved output byte |
| out_primed | output | 1 | All branches hold real data for this and later outputs |

## Verification
The behaviour hardest to reach from the ports is the long branch wrapping its circular pointer while strobes arrive with irregular gaps. Exercising it needs more than (BRANCHES-1)·STAGE·BRANCHES strobes, with idle cycles placed at positions that do not repeat with the commutator period. The bench therefore runs a few hundred bytes through a small configuration. It inserts one-cycle and two-cycle gaps on two unrelated periods and drives junk data during the gaps. It then resets mid-stream and streams again, so that any data or pointer state left over from the first run shows up as non-zero bytes during refill.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Start offset, in bytes, of the delay slice belonging to branch k.
  function automatic int unsigned ilv_base(input int unsigned k, input int unsigned stage);
    if (k < 2) return 0;
    return stage * k * (k - 1) / 2;
  endfunction
endpackage

// File: rtl/ilv_commutator.sv
module ilv_commutator #(
  parameter int BRANCHES = 4,
  parameter int SW       = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [SW-1:0] sel
);
  localparam logic [SW-1:0] LAST = SW'(BRANCHES - 1);

  always_ff @(posedge clk) begin
    if (rst)
      sel <= '0;
    else if (adv)
      sel <= (sel == LAST) ? '0 : sel + 1'b1;
  end
endmodule

// File: rtl/ilv_ptr_bank.sv
module ilv_ptr_bank #(
  parameter int BRANCHES = 4,
  parameter int STAGE    = 2,
  parameter int SW       = 2,
  parameter int PW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [SW-1:0] sel,
  output logic [PW-1:0] ptr_sel
);
  logic [PW-1:0] ptrs [BRANCHES];

  assign ptrs[0] = '0;

  for (genvar k = 1; k < BRANCHES; k++) begin : g_branch
    localparam logic [PW-1:0] WRAP = PW'(k * STAGE - 1);
    logic [PW-1:0] p;
    always_ff @(posedge clk) begin
      if (rst)
        p <= '0;
      else if (adv && sel == SW'(k))
        p <= (p == WRAP) ? '0 : p + 1'b1;
    end
    assign ptrs[k] = p;
  end

  always_comb begin
    ptr_sel = '0;
    for (int k = 0; k < BRANCHES; k++)
      if (sel == SW'(k)) ptr_sel = ptrs[k];
  end
endmodule

// File: rtl/ilv_delay_ram.sv
module ilv_delay_ram #(
  parameter int DEPTH = 12,
  parameter int AW    = 4,
  parameter int W     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Read-first: the old slot contents leave as the new byte goes in.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else if (we) begin
      rdata     <= mem[addr];
      mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/ilv_fill.sv
module ilv_fill #(
  parameter int LAT = 24,
  parameter int CW  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic primed
);
  localparam logic [CW-1:0] LIM = CW'(LAT);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (adv && cnt != LIM)
      cnt <= cnt + 1'b1;
  end

  assign primed = (cnt == LIM);
endmodule

// File: rtl/conv_interleaver.sv
module conv_interleaver #(
  parameter int BRANCHES = 4,
  parameter int STAGE    = 2,
  parameter int W        = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_stb,
  input  logic [W-1:0] in_data,
  output logic         out_stb,
  output logic [W-1:0] out_data,
  output logic         out_primed
);
  import ilv_pkg::*;

  localparam int SW    = (BRANCHES > 1) ? $clog2(BRANCHES) : 1;
  localparam int DEPTH = STAGE * BRANCHES * (BRANCHES - 1) / 2;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW    = $clog2((BRANCHES - 1) * STAGE + 1);
  localparam int LAT   = (BRANCHES - 1) * STAGE * BRANCHES;
  localparam int CW    = $clog2(LAT + 1);

  logic [SW-1:0] sel_w;
  logic [PW-1:0] ptr_w;
  logic [AW-1:0] base_w;
  logic [AW-1:0] addr_w;
  logic [W-1:0]  ram_q;
  logic          we_w;
  logic          primed_w;

  logic          stb_q;
  logic          pass_q;
  logic [W-1:0]  byp_q;
  logic          primed_q;

  ilv_commutator #(.BRANCHES(BRANCHES), .SW(SW)) u_comm (
    .clk(clk), .rst(rst), .adv(in_stb), .sel(sel_w)
  );

  ilv_ptr_bank #(.BRANCHES(BRANCHES), .STAGE(STAGE), .SW(SW), .PW(PW)) u_ptrs (
    .clk(clk), .rst(rst), .adv(in_stb), .sel(sel_w), .ptr_sel(ptr_w)
  );

  always_comb begin
    base_w = '0;
    for (int k = 0; k < BRANCHES; k++)
      if (sel_w == SW'(k)) base_w = AW'(ilv_base(k, STAGE));
  end

  assign addr_w = base_w + AW'(ptr_w);
  assign we_w   = in_stb && (sel_w != '0);

  ilv_delay_ram #(.DEPTH(DEPTH), .AW(AW), .W(W)) u_ram (
    .clk(clk), .rst(rst), .we(we_w), .addr(addr_w), .wdata(in_data), .rdata(ram_q)
  );

  ilv_fill #(.LAT(LAT), .CW(CW)) u_fill (
    .clk(clk), .rst(rst), .adv(in_stb), .primed(primed_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q    <= 1'b0;
      pass_q   <= 1'b0;
      byp_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      stb_q <= in_stb;
      if (in_stb) begin
        pass_q   <= (sel_w == '0);
        byp_q    <= in_data;
        primed_q <= primed_w;
      end
    end
  end

  assign out_stb    = stb_q;
  assign out_data   = pass_q ? byp_q : ram_q;
  assign out_primed = primed_q;
endmodule

// File: rtl/ilv_checker.sv
module ilv_checker #(
  parameter int BRANCHES = 4,
  parameter int W        = 8,
  parameter int SW       = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          in_stb,
  input logic [W-1:0]  in_data,
  input logic          out_stb,
  input logic [W-1:0]  out_data,
  input logic          out_primed,
  input logic [SW-1:0] sel
);
  localparam logic [SW-1:0] LAST = SW'(BRANCHES - 1);

  assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (in_stb && sel == '0) |=> (out_stb && out_data == $past(in_data)));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (in_stb && sel != LAST) |=> (sel == $past(sel) + 1'b1));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (in_stb && sel == LAST) |=> (sel == '0));

  assert_idle_sel_R3: assert property (@(posedge clk) disable iff (rst)
    !in_stb |=> $stable(sel));

  assert_stb_on_R4: assert property (@(posedge clk) disable iff (rst)
    in_stb |=> out_stb);

  assert_stb_off_R4: assert property (@(posedge clk) disable iff (rst)
    !in_stb |=> !out_stb);

  assert_primed_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    out_primed |=> out_primed);

  assert_primed_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_primed) |-> out_stb);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_stb |=> ($stable(out_data) && $stable(out_primed)));

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (sel == '0 && !out_stb && !out_primed && out_data == '0));
endmodule

bind conv_interleaver ilv_checker #(.BRANCHES(BRANCHES), .W(W), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .in_stb(in_stb), .in_data(in_data),
  .out_stb(out_stb), .out_data(out_data), .out_primed(out_primed), .sel(sel_w)
);

// File: tb/conv_interleaver_tb.sv
`timescale 1ns/1ps
module conv_interleaver_tb;
  localparam int N   = 4;
  localparam int M   = 2;
  localparam int W   = 8;
  localparam int LAT = (N - 1) * M * N;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_stb;
  logic [W-1:0] in_data;
  logic         out_stb;
  logic [W-1:0] out_data;
  logic         out_primed;

  always #2 clk = ~clk;

  conv_interleaver #(.BRANCHES(N), .STAGE(M), .W(W)) u_dut (
    .clk(clk), .rst(rst), .in_stb(in_stb), .in_data(in_data),
    .out_stb(out_stb), .out_data(out_data), .out_primed(out_primed)
  );

  int           ncmp = 0;
  int           nbad = 0;
  logic [W-1:0] hist [0:1023];
  int           j;
  bit           gap_prev;
  logic [W-1:0] last_out;
  logic         last_primed;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    ncmp++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Strobe one byte, then check its output one cycle later.
  task automatic push(input logic [W-1:0] d);
    int k, dly;
    logic [W-1:0] e;
    in_stb  = 1'b1;
    in_data = d;
    hist[j] = d;
    k   = j % N;
    dly = k * M * N;
    e   = (j >= dly) ? hist[j - dly] : '0;
    @(posedge clk); #1;
    chk(out_stb == 1'b1, "R4", "out_stb after strobe", out_stb, 1);
    if (gap_prev)
      chk(out_data == e, "R3", "byte after idle gap", out_data, e);
    else if (k == 0)
      chk(out_data == e, "R1", "branch 0 pass-through", out_data, e);
    else if (j >= dly)
      chk(out_data == e, "R2", "delayed byte", out_data, e);
    else
      chk(out_data == e, "R5", "unfilled line reads zero", out_data, e);
    chk(out_primed == (j >= LAT), "R6", "primed flag", out_primed, (j >= LAT));
    last_out    = out_data;
    last_primed = out_primed;
    gap_prev    = 1'b0;
    j++;
  endtask

  task automatic idle(input logic [W-1:0] junk);
    in_stb  = 1'b0;
    in_data = junk;
    @(posedge clk); #1;
    chk(out_stb == 1'b0, "R4", "out_stb idle", out_stb, 0);
    chk(out_data == last_out, "R7", "out_data hold", out_data, last_out);
    chk(out_primed == last_primed, "R7", "primed hold", out_primed, last_primed);
    gap_prev = 1'b1;
  endtask

  task automatic do_reset();
    rst    = 1'b1;
    in_stb = 1'b0;
    repeat (2) begin @(posedge clk); #1; end
    chk(out_stb == 1'b0, "R8", "out_stb in reset", out_stb, 0);
    chk(out_primed == 1'b0, "R8", "primed in reset", out_primed, 0);
    chk(out_data == '0, "R8", "out_data in reset", out_data, 0);
    rst         = 1'b0;
    j           = 0;
    gap_prev    = 1'b0;
    last_out    = '0;
    last_primed = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    ncmp++;
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    rst     = 1'b1;
    in_stb  = 1'b0;
    in_data = '0;
    j       = 0;
    @(posedge clk); #1;
    do_reset();

    // Run 1: irregular gaps with junk data driven during idle cycles.
    for (int i = 0; i < 300; i++) begin
      push(W'((i * 53 + 7) & 8'hFF));
      if (i % 7 == 3) idle(W'(i ^ 8'hA5));
      if (i % 11 == 5) begin idle(8'hFF); idle(8'h3C); end
    end

    // Mid-stream reset: refill must show zeros, not old contents (R8).
    do_reset();
    for (int i = 0; i < 120; i++) begin
      push(W'((i * 37 + 11) & 8'hFF));
      if (i >= LAT && i % 13 == 0) idle(8'h5A);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule